// File: doc/BRIEF.md
# Upset-Tolerant Dual-Copy Register

This block is a register word, one bit wide or more, that survives a single-event upset in its storage. Every bit is held twice, in two independent copies loaded from the same input on the same clock edge. A keeper merges the two copies in the manner of a Muller C-element. While the copies agree it passes their common value. While they disagree it holds the value it had before. A flip in one copy of a bit therefore never reaches the output.

The word is built from identical per-bit cells placed by a generate loop. A synchronous reset loads both copies and the keeper with the same reset value. A capture enable opens the capture window. In the default output mode the output follows the data input while that window is open. A per-bit mismatch flag is raised whenever the two copies of a bit differ, so that upstream logic can log the error.

Each copy has its own upset-injection input. These inputs exist only for verification and are tied low in a real design.

Top module: `hreg_word`

## Requirements
- R1: A synchronous reset sets both copies and the keeper of every bit to `RST_VAL`, clears `mismatch`, and takes priority over `en`. After the reset edge, with `en` low, `q` equals `RST_VAL`.
- R2: When `en` is high and `rst` is low at a rising edge, both copies of every bit load `d`.
- R3: With `OUT_MODE` set to flow-through (the default), `q` equals `d` whenever `en` is high and `rst` is low, without waiting for a clock edge.
- R4: With `en` low, every bit whose two copies agree drives `q` with their common value.
- R5: With `en` low, every bit whose two copies disagree keeps on `q` the value that bit had before the disagreement began.
- R6: An upset in exactly one copy of a bit, with `en` low, leaves `q` unchanged.
- R7: A high `upset_a[i]` (or `upset_b[i]`) at a rising edge inverts only copy A (or copy B) of bit i. The inversion is applied after any capture in that edge.
- R8: `mismatch[i]` is 1 exactly when the two copies of bit i differ.
- R9: A capture with no upset input active clears every mismatch on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Capture window; high loads `d` into both copies |
| d | input | WIDTH | Data to store |
| upset_a | input | WIDTH | Per-bit inversion of copy A, for fault injection only |
| upset_b | input | WIDTH | Per-bit inversion of copy B, for fault injection only |
| q | output | WIDTH | Merged, upset-tolerant output |
| mismatch | output | WIDTH | Per-bit flag: the two copies differ |

## Verification
On every cycle the assertions check several properties:
- the reset values once reset is released;
- that a capture with no upset leaves both copies equal to the captured data;
- that each injection input inverts only its own copy;
- that agreeing copies drive the output;
- that a one-sided upset from an agreeing state never moves the output.

Two behaviours can only be shown by the bench's scenarios. One is the hold of the previous value through layered upsets that first split the copies and then rejoin them. The other is the combinational flow-through of the input while the capture window is open. The reset-over-capture priority and the clearing of a wide mismatch by reset are also shown there.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

   // Output variant of the word: merged copies only, or input flow-through while capturing
   typedef enum logic {
      OUT_MERGED = 1'b0,
      OUT_FLOW   = 1'b1
   } out_mode_e;

   // C-element style merge: agreement passes, disagreement keeps the held value
   function automatic logic c_merge(input logic a, input logic b, input logic held);
      return (a == b) ? a : held;
   endfunction

endpackage

// File: rtl/hreg_copy.sv
module hreg_copy #(
   parameter logic RV = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic d,
   input  logic flip,
   output logic q
);

   logic next_val;

   always_comb begin
      next_val = en ? d : q;
      next_val = next_val ^ flip;
   end

   always_ff @(posedge clk) begin
      if (rst) q <= RV;
      else     q <= next_val;
   end

endmodule

// File: rtl/hreg_keeper.sv
module hreg_keeper #(
   parameter logic RV = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic a,
   input  logic b,
   output logic merged,
   output logic held
);

   assign merged = hreg_pkg::c_merge(a, b, held);

   always_ff @(posedge clk) begin
      if (rst) held <= RV;
      else     held <= merged;
   end

endmodule

// File: rtl/hreg_cell.sv
module hreg_cell #(
   parameter logic RV = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic d,
   input  logic ups_a,
   input  logic ups_b,
   output logic merged,
   output logic mis,
   output logic cpy_a,
   output logic cpy_b,
   output logic held
);

   hreg_copy #(.RV(RV)) u_copy_a (
      .clk(clk), .rst(rst), .en(en), .d(d), .flip(ups_a), .q(cpy_a)
   );

   hreg_copy #(.RV(RV)) u_copy_b (
      .clk(clk), .rst(rst), .en(en), .d(d), .flip(ups_b), .q(cpy_b)
   );

   hreg_keeper #(.RV(RV)) u_keep (
      .clk(clk), .rst(rst), .a(cpy_a), .b(cpy_b), .merged(merged), .held(held)
   );

   assign mis = cpy_a ^ cpy_b;

endmodule

// File: rtl/hreg_word.sv
module hreg_word #(
   parameter int                  WIDTH    = 8,
   parameter logic [WIDTH-1:0]    RST_VAL  = '0,
   parameter hreg_pkg::out_mode_e OUT_MODE = hreg_pkg::OUT_FLOW
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] d,
   input  logic [WIDTH-1:0] upset_a,
   input  logic [WIDTH-1:0] upset_b,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] mismatch
);

   localparam int LAST = WIDTH - 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("hreg_word: WIDTH must be at least 1");
   end

   logic [LAST:0] merged;
   logic [LAST:0] cpy_a;
   logic [LAST:0] cpy_b;
   logic [LAST:0] hold;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      hreg_cell #(.RV(RST_VAL[i])) u_cell (
         .clk   (clk),
         .rst   (rst),
         .en    (en),
         .d     (d[i]),
         .ups_a (upset_a[i]),
         .ups_b (upset_b[i]),
         .merged(merged[i]),
         .mis   (mismatch[i]),
         .cpy_a (cpy_a[i]),
         .cpy_b (cpy_b[i]),
         .held  (hold[i])
      );
   end

   if (OUT_MODE == hreg_pkg::OUT_FLOW) begin : g_flow
      assign q = (en && !rst) ? d : merged;
   end else begin : g_merged
      assign q = merged;
   end

endmodule

// File: rtl/hreg_word_chk.sv
module hreg_word_chk #(
   parameter int               WIDTH   = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [WIDTH-1:0] d,
   input logic [WIDTH-1:0] upset_a,
   input logic [WIDTH-1:0] upset_b,
   input logic [WIDTH-1:0] q,
   input logic [WIDTH-1:0] mismatch,
   input logic [WIDTH-1:0] cpy_a,
   input logic [WIDTH-1:0] cpy_b,
   input logic [WIDTH-1:0] hold
);

   p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (hold == RST_VAL && cpy_a == RST_VAL && cpy_b == RST_VAL && mismatch == '0));

   p_capture_r2: assert property (@(posedge clk) disable iff (rst)
      (en && upset_a == '0 && upset_b == '0) |=> (cpy_a == $past(d) && cpy_b == $past(d)));

   p_agree_out_r4: assert property (@(posedge clk) disable iff (rst)
      (!en && mismatch == '0) |-> q == cpy_a);

   p_single_upset_r6: assert property (@(posedge clk) disable iff (rst)
      (!en && mismatch == '0 && (upset_a & upset_b) == '0) |=> (en || rst || q == $past(q)));

   p_inject_a_r7: assert property (@(posedge clk) disable iff (rst)
      !en |=> cpy_a == ($past(cpy_a) ^ $past(upset_a)));

   p_inject_b_r7: assert property (@(posedge clk) disable iff (rst)
      !en |=> cpy_b == ($past(cpy_b) ^ $past(upset_b)));

   p_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (en && upset_a == '0 && upset_b == '0) |=> mismatch == '0);

endmodule

bind hreg_word hreg_word_chk #(.WIDTH(WIDTH), .RST_VAL(RST_VAL)) u_chk (
   .clk(clk), .rst(rst), .en(en), .d(d), .upset_a(upset_a), .upset_b(upset_b),
   .q(q), .mismatch(mismatch), .cpy_a(cpy_a), .cpy_b(cpy_b), .hold(hold)
);

// File: tb/hreg_word_test.sv
module hreg_word_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en  = 1'b0;
   logic [W-1:0] d   = '0;
   logic [W-1:0] upset_a = '0;
   logic [W-1:0] upset_b = '0;
   logic [W-1:0] q;
   logic [W-1:0] mismatch;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   hreg_word #(.WIDTH(W), .RST_VAL(8'h00), .OUT_MODE(hreg_pkg::OUT_FLOW)) uut (
      .clk(clk), .rst(rst), .en(en), .d(d), .upset_a(upset_a), .upset_b(upset_b),
      .q(q), .mismatch(mismatch)
   );

   typedef struct packed {
      logic         en;
      logic [W-1:0] d;
      logic [W-1:0] ua;
      logic [W-1:0] ub;
      logic [W-1:0] q;
      logic [W-1:0] mis;
   } vec_t;

   localparam int NV = 10;
   // Each row is applied for one rising edge and checked one time unit after it.
   // Tags: R2 R3 R4 R5 R6 R7 R8 R9
   localparam vec_t TBL [NV] = '{
      '{1'b1, 8'hA5, 8'h00, 8'h00, 8'hA5, 8'h00},  // R2 capture
      '{1'b0, 8'hFF, 8'h00, 8'h00, 8'hA5, 8'h00},  // R4 closed window ignores d
      '{1'b0, 8'h00, 8'h01, 8'h00, 8'hA5, 8'h01},  // R6 R7 upset on copy A
      '{1'b0, 8'h00, 8'h00, 8'h80, 8'hA5, 8'h81},  // R5 R6 R8 upset on copy B, other bit
      '{1'b1, 8'h3C, 8'h00, 8'h00, 8'h3C, 8'h00},  // R9 capture clears
      '{1'b0, 8'h00, 8'hF0, 8'h0F, 8'h3C, 8'hFF},  // R5 every bit split
      '{1'b0, 8'h00, 8'hF0, 8'h00, 8'h3C, 8'h0F},  // R4 R5 upper half rejoins
      '{1'b0, 8'h00, 8'h00, 8'h0F, 8'h3C, 8'h00},  // R4 lower half rejoins
      '{1'b1, 8'h5A, 8'h00, 8'h00, 8'h5A, 8'h00},  // R2 R3
      '{1'b0, 8'h00, 8'h00, 8'h00, 8'h5A, 8'h00}   // R4 hold after capture
   };

   task automatic check(input string tag, input logic [W-1:0] act_q, input logic [W-1:0] exp_q,
                        input logic [W-1:0] act_m, input logic [W-1:0] exp_m);
      n_vec++;
      if (act_q !== exp_q || act_m !== exp_m) begin
         n_bad++;
         $display("FAIL %s: q=%h mismatch=%h, expected q=%h mismatch=%h",
                  tag, act_q, act_m, exp_q, exp_m);
      end
   endtask

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1 check("R1 reset state", q, 8'h00, mismatch, 8'h00);

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         en      = TBL[k].en;
         d       = TBL[k].d;
         upset_a = TBL[k].ua;
         upset_b = TBL[k].ub;
         @(posedge clk);
         #1 check($sformatf("vector %0d (R2 R4 R5 R6 R7 R8 R9)", k), q, TBL[k].q, mismatch, TBL[k].mis);
      end

      // R3: flow-through with no clock edge
      @(negedge clk);
      en = 1'b1; d = 8'hC3; upset_a = '0; upset_b = '0;
      #1 check("R3 flow-through", q, 8'hC3, mismatch, 8'h00);
      en = 1'b0; d = 8'h00;
      #0.5 check("R4 window closed before edge", q, 8'h5A, mismatch, 8'h00);
      @(posedge clk);
      #1 check("R4 nothing captured", q, 8'h5A, mismatch, 8'h00);

      // R6 R8: whole copy A flipped, output holds
      @(negedge clk);
      upset_a = 8'hFF;
      @(posedge clk);
      #1 check("R6 full copy A upset", q, 8'h5A, mismatch, 8'hFF);

      // R1: reset clears a full mismatch and beats a capture request
      @(negedge clk);
      upset_a = '0; rst = 1'b1; en = 1'b1; d = 8'hFF;
      @(posedge clk);
      #1 check("R1 reset over capture", q, 8'h5A ^ 8'h5A, mismatch, 8'h00);
      @(negedge clk);
      rst = 1'b0; en = 1'b0; d = 8'h00;
      #1 check("R1 reset value held", q, 8'h00, mismatch, 8'h00);

      // R7: upset during a capture lands on the captured value of copy B
      @(negedge clk);
      en = 1'b1; d = 8'h0F; upset_b = 8'h10;
      @(posedge clk);
      #1 check("R7 upset after capture", q, 8'h0F, mismatch, 8'h10);
      @(negedge clk);
      en = 1'b1; d = 8'h0F; upset_b = '0;
      @(posedge clk);
      @(negedge clk);
      en = 1'b0;
      #1 check("R9 recapture clears", q, 8'h0F, mismatch, 8'h00);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule